// File: doc/BRIEF.md
# Per-Pin Input Interrupt Controller

This block watches a bank of general-purpose input pins (40 by default) and turns pin activity into interrupt requests. Each pin carries a small configuration word. The word chooses how the pin triggers: off, rising edge, falling edge, either edge, low level or high level. It also holds a wakeup enable and five routing enables. Pin inputs are first brought into the clock domain by a two-flop synchroniser. Edges are then found by comparing the synchronised value with the value one cycle earlier.

Detected events set sticky bits in a pin status register. Software reaches that register through three write ports: a plain write, a write-1-to-set port and a write-1-to-clear port. The status is masked per destination to give five views: application-CPU normal, application-CPU non-maskable, protocol-CPU normal, protocol-CPU non-maskable, and an SDIO-side line. Each view can be read back and drives one request output. A pin in a level mode with its wakeup enable set drives a wakeup output. That output matters only while the system is in light sleep.

Register access uses a plain write strobe with address and data, and a combinational read port. Both are control paths with no handshake. A write lands on the next rising clock edge. Read data follows the read address in the same cycle.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every status bit, every pin configuration word, all five request outputs and the wakeup output are zero.
- R2: The trigger field is bits [2:0] of a pin's configuration word: 0 off, 1 rising, 2 falling, 3 either edge, 4 low level, 5 high level. Codes 6 and 7 act as off.
- R3: An input change is captured in the status at the third rising clock edge after the change. Rising mode ignores falling transitions, and falling mode ignores rising transitions.
- R4: In level modes the status bit is set again on every cycle the level holds, so a clear write only sticks once the level has gone away. A low-level pin that is already low raises its bit one edge after the mode is written.
- R5: Status word w (pins 32w..32w+31) has a plain write at address 3w, write-1-to-set at 3w+1 and write-1-to-clear at 3w+2. Set and clear writes change only the bits written as 1. Reading 3w returns the word.
- R6: When a hardware event and a clear write hit the same status bit on the same edge, the bit ends up set.
- R7: Configuration bits [8:4] are route enables: bit 4 application normal, bit 5 application non-maskable, bit 6 protocol normal, bit 7 protocol non-maskable, bit 8 SDIO side. Destination d, status word w, reads at address 16+2d+w as status AND that destination's enable. Pin p's configuration reads and writes at address 32+p.
- R8: Pins 32 to 39 sit in bits [7:0] of status word 1. Its upper 24 bits read as zero and ignore writes.
- R9: Request output irq_o[d] is high exactly when destination d's masked vector is nonzero.
- R10: The wakeup output (configuration bit 3 enables a pin) is high while any enabled pin is in a level mode with its level present. It does not depend on the status register.
- R11: Writing a new trigger type never creates an edge event by itself, even when the pin already sits at the new edge's end level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS | Asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data, combinational |
| irq_o | output | 5 | Request per destination, ordered as route bits |
| wake_o | output | 1 | Level wakeup request |

## Verification
The bench times an input change against its status bit through the synchroniser. A design with one stage too many or too few would report the bit a cycle late or early. It places a clear write on the same edge as an edge event, where a clear-wins priority would lose the event. It clears a held high-level pin, which must re-assert, and it writes a mode over a pin already at that level, where a design that reset its previous sample would invent an edge. It also writes all ones to the upper status word and checks mode codes 6 and 7 and the per-destination views, so leaked upper bits, a decoded stray mode or a swapped route bit show up as wrong read data.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NDEST       = 5;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 7;
  localparam int A_DEST_BASE = 16;
  localparam int A_CFG_BASE  = 32;

  typedef enum logic [2:0] {
    TRIG_OFF  = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_ANY  = 3'd3,
    TRIG_LOW  = 3'd4,
    TRIG_HIGH = 3'd5
  } trig_e;

  typedef struct packed {
    logic [NDEST-1:0] route;
    logic             wake;
    logic [2:0]       trig;
  } pin_cfg_t;

  localparam int CFG_W = $bits(pin_cfg_t);
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [2:0]       trig_i [NPINS],
  output logic [NPINS-1:0] evt_o,
  output logic [NPINS-1:0] lvl_act_o
);
  // previous sample refreshed every cycle, whatever the mode
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic rise, fall;
    assign rise = lvl_i[g] & ~prev_q[g];
    assign fall = ~lvl_i[g] & prev_q[g];

    always_comb begin
      case (trig_i[g])
        TRIG_LOW:  lvl_act_o[g] = ~lvl_i[g];
        TRIG_HIGH: lvl_act_o[g] = lvl_i[g];
        default:   lvl_act_o[g] = 1'b0;
      endcase
      case (trig_i[g])
        TRIG_RISE: evt_o[g] = rise;
        TRIG_FALL: evt_o[g] = fall;
        TRIG_ANY:  evt_o[g] = rise | fall;
        TRIG_LOW,
        TRIG_HIGH: evt_o[g] = lvl_act_o[g];
        default:   evt_o[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 40
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  input  logic [NPINS-1:0]            evt_i,
  output logic [NPINS-1:0]            st_q,
  output pin_cfg_t                    cfg_q [NPINS],
  output logic [NDEST-1:0][NPINS-1:0] dest_o
);
  localparam int NWORDS = (NPINS + DATA_W - 1) / DATA_W;
  localparam int PADW   = NWORDS * DATA_W;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    localparam int W = g / DATA_W;
    localparam int B = g % DATA_W;
    localparam logic [ADDR_W-1:0] A_PLAIN = ADDR_W'(3 * W);
    localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(3 * W + 1);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(3 * W + 2);
    localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(A_CFG_BASE + g);
    logic nxt;

    always_comb begin
      nxt = st_q[g];
      if (wr_en && wr_addr == A_PLAIN)               nxt = wr_data[B];
      if (wr_en && wr_addr == A_SET && wr_data[B])   nxt = 1'b1;
      if (wr_en && wr_addr == A_CLR && wr_data[B])   nxt = 1'b0;
      if (evt_i[g])                                  nxt = 1'b1;  // hardware set wins
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g]  <= 1'b0;
        cfg_q[g] <= '0;
      end else begin
        st_q[g] <= nxt;
        if (wr_en && wr_addr == A_CFG) cfg_q[g] <= pin_cfg_t'(wr_data[CFG_W-1:0]);
      end
    end

    for (genvar d = 0; d < NDEST; d++) begin : g_dest
      assign dest_o[d][g] = st_q[g] & cfg_q[g].route[d];
    end
  end

  logic [PADW-1:0] st_pad;
  logic [PADW-1:0] dest_pad [NDEST];
  assign st_pad = PADW'(st_q);
  for (genvar d = 0; d < NDEST; d++) begin : g_pad
    assign dest_pad[d] = PADW'(dest_o[d]);
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (rd_addr == ADDR_W'(3 * w)) rd_data = st_pad[w*DATA_W +: DATA_W];
      for (int d = 0; d < NDEST; d++) begin
        if (rd_addr == ADDR_W'(A_DEST_BASE + NWORDS * d + w))
          rd_data = dest_pad[d][w*DATA_W +: DATA_W];
      end
    end
    for (int p = 0; p < NPINS; p++) begin
      if (rd_addr == ADDR_W'(A_CFG_BASE + p)) rd_data = DATA_W'(cfg_q[p]);
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NDEST-1:0]  irq_o,
  output logic              wake_o
);
  logic [NPINS-1:0]            pin_s;
  logic [NPINS-1:0]            hw_evt;
  logic [NPINS-1:0]            lvl_act;
  logic [NPINS-1:0]            st_q;
  logic [NPINS-1:0]            wake_en;
  logic [NDEST-1:0][NPINS-1:0] dest;
  pin_cfg_t                    cfg_q [NPINS];
  logic [2:0]                  trig  [NPINS];

  gpio_irq_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_cfg
    assign trig[g]    = cfg_q[g].trig;
    assign wake_en[g] = cfg_q[g].wake;
  end

  gpio_irq_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl_i(pin_s), .trig_i(trig),
    .evt_o(hw_evt), .lvl_act_o(lvl_act)
  );

  gpio_irq_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_i(hw_evt), .st_q(st_q), .cfg_q(cfg_q), .dest_o(dest)
  );

  for (genvar d = 0; d < NDEST; d++) begin : g_irq
    assign irq_o[d] = |dest[d];
  end

  assign wake_o = |(lvl_act & wake_en);
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [NPINS-1:0]  st_q,
  input logic [NPINS-1:0]  hw_evt,
  input logic [NPINS-1:0]  lvl_act,
  input logic [NDEST-1:0]  irq_o,
  input logic              wake_o
);
  localparam int NWORDS = (NPINS + DATA_W - 1) / DATA_W;
  localparam int LASTB  = NPINS - DATA_W * (NWORDS - 1);
  localparam logic [DATA_W-1:0] TOPMASK =
    (LASTB == DATA_W) ? '1 : DATA_W'((64'd1 << LASTB) - 64'd1);
  localparam logic [ADDR_W-1:0] A_TOP = ADDR_W'(3 * (NWORDS - 1));

  // R6: a hardware event always leaves its status bit set
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(hw_evt)) == $past(hw_evt)));

  // R5: no write and no event keeps the status unchanged
  a_r5_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && hw_evt == '0) |=> $stable(st_q));

  // R8: unused bits of the top status word read as zero
  a_r8_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_TOP) |-> ((rd_data & ~TOPMASK) == '0));

  // R9: a request needs some status bit behind it
  a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> (|st_q));

  // R10: wakeup only with an active level condition
  a_r10_wake_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (|lvl_act));
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .st_q(st_q), .hw_evt(hw_evt), .lvl_act(lvl_act), .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;
  localparam int NP = 40;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_i = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic [4:0]    irq_o;
  logic          wake_o;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NP)) u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o), .wake_o(wake_o)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic [31:0]   exp;
    string         tag;
  } item_t;

  item_t q[$];
  int pending = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // monitor: pops expected reads and compares against the read port
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        rd_addr = it.addr;
        #1;
        n_chk++;
        if (rd_data !== it.exp) begin
          n_fail++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, rd_data, it.exp);
        end
        pending--;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input int p, input logic [2:0] trig, input logic wk, input logic [4:0] route);
    wreg(32 + p, {23'd0, route, wk, trig});
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    item_t it;
    it.addr = AW'(a); it.exp = e; it.tag = tag;
    pending++;
    q.push_back(it);
    wait (pending == 0);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, e);
    end
  endtask

  function automatic int dst(input int d, input int w);
    return 16 + 2 * d + w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(0, 0, "R1 status lo");
    rd(3, 0, "R1 status hi");
    rd(32 + 3, 0, "R1 cfg");
    chk(32'(irq_o), 0, "R1 irq");
    chk(32'(wake_o), 0, "R1 wake");

    // R3 rising edge on pin 3, routed to destination 0
    cfg(3, 3'd1, 1'b0, 5'b00001);
    pin_i[3] = 1'b1; step(3);
    rd(0, 32'h8, "R3 rising sets");
    rd(dst(0, 0), 32'h8, "R7 dest0 view");
    chk(32'(irq_o), 32'h1, "R9 irq dest0");
    wreg(2, 32'h8);
    rd(0, 0, "R5 clear");
    pin_i[3] = 1'b0; step(3);
    rd(0, 0, "R3 rising ignores fall");

    // R3 falling on pin 5
    cfg(5, 3'd2, 1'b0, 5'b0);
    pin_i[5] = 1'b1; step(3);
    rd(0, 0, "R3 falling ignores rise");
    pin_i[5] = 1'b0; step(3);
    rd(0, 32'h20, "R3 falling sets");
    wreg(2, 32'h20);

    // R3 any edge on pin 6
    cfg(6, 3'd3, 1'b0, 5'b0);
    pin_i[6] = 1'b1; step(3);
    rd(0, 32'h40, "R3 any rise");
    wreg(2, 32'h40);
    pin_i[6] = 1'b0; step(3);
    rd(0, 32'h40, "R3 any fall");
    wreg(2, 32'h40);

    // R2 codes 6 and 7 are off
    cfg(8, 3'd6, 1'b0, 5'b0);
    pin_i[8] = 1'b1; step(3);
    rd(0, 0, "R2 code6 rise");
    cfg(8, 3'd7, 1'b0, 5'b0);
    pin_i[8] = 1'b0; step(3);
    rd(0, 0, "R2 code7 fall");

    // R11 mode change at settled level
    pin_i[9] = 1'b1; step(3);
    cfg(9, 3'd1, 1'b0, 5'b0); step(3);
    rd(0, 0, "R11 rising after high");
    cfg(9, 3'd3, 1'b0, 5'b0); step(3);
    rd(0, 0, "R11 any after high");

    // R4 R10 high level on pin 35, protocol non-maskable, wake enabled
    cfg(35, 3'd5, 1'b1, 5'b01000);
    pin_i[35] = 1'b1; step(3);
    rd(3, 32'h8, "R4 high level sets");
    rd(dst(3, 1), 32'h8, "R7 dest3 hi view");
    rd(dst(2, 1), 32'h0, "R7 dest2 hi masked");
    chk(32'(wake_o), 1, "R10 wake high");
    chk(32'(irq_o), 32'h8, "R9 irq dest3");
    wreg(5, 32'h8);
    rd(3, 32'h8, "R4 clear while held");
    pin_i[35] = 1'b0; step(3);
    chk(32'(wake_o), 0, "R10 wake released");
    wreg(5, 32'h8);
    rd(3, 0, "R4 clear after release");

    // R8 upper bits of word 1
    wreg(3, 32'hFFFF_FFFF);
    rd(3, 32'hFF, "R8 upper zero");
    wreg(5, 32'hFFFF_FFFF);
    rd(3, 0, "R8 clear all");

    // R4 low level already present on pin 7
    cfg(7, 3'd4, 1'b1, 5'b0); step(1);
    rd(0, 32'h80, "R4 low level immediate");
    chk(32'(wake_o), 1, "R10 wake low");
    cfg(7, 3'd0, 1'b0, 5'b0);
    wreg(2, 32'h80);
    rd(0, 0, "R4 low off and cleared");
    chk(32'(wake_o), 0, "R10 wake off");

    // R5 write ports
    wreg(0, 32'hA5);
    rd(0, 32'hA5, "R5 plain");
    wreg(1, 32'h100);
    rd(0, 32'h1A5, "R5 set");
    wreg(2, 32'h5);
    rd(0, 32'h1A0, "R5 clear");
    wreg(0, 0);

    // R6 event and clear on the same edge
    cfg(10, 3'd1, 1'b0, 5'b0);
    pin_i[10] = 1'b1; step(2);
    wreg(2, 32'h400);
    rd(0, 32'h400, "R6 set wins");
    wreg(2, 32'h400);
    rd(0, 0, "R6 later clear");

    // R7 R9 routing to all, then SDIO only
    cfg(3, 3'd0, 1'b0, 5'b11111);
    wreg(1, 32'h8);
    for (int d = 0; d < 5; d++) rd(dst(d, 0), 32'h8, "R7 all routes");
    chk(32'(irq_o), 32'h1F, "R9 irq all");
    cfg(3, 3'd0, 1'b0, 5'b10000);
    rd(32 + 3, 32'h100, "R7 cfg readback");
    rd(dst(1, 0), 0, "R7 dest1 masked");
    rd(dst(4, 0), 32'h8, "R7 dest4 view");
    chk(32'(irq_o), 32'h10, "R9 irq sdio");
    wreg(2, 32'h8);
    chk(32'(irq_o), 0, "R9 irq cleared");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule